// File: doc/BRIEF.md
# Four-Way Address Translation Buffer

This block is a translation lookaside buffer for one access stream. It turns 32-bit logical addresses into 32-bit physical addresses using a small set-associative store of page descriptors. A lookup is offered on the request port and the result comes back one cycle later. The result is one of three outcomes: a hit with the physical address, a protection fault, or a miss. On a miss the block asks an external table-walk agent for the descriptor of the missing page. It holds further requests until that descriptor arrives, stores it, and then returns the result of the waiting lookup.

The store holds 64 entries, arranged as 16 sets of 4 ways. Page size is chosen per lookup, either 4 KB or 8 KB. Choosing the size moves the set-index field and the tag. Each entry records the page size it was filled under, so an entry only matches lookups of that same size. Each descriptor carries a supervisor-only flag and a write-protect flag, and both are checked on every translated access. With translation turned off the block passes addresses through unchanged. A flush input empties the whole store in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `fill_req` are 0, `req_ready` is 1, and every entry is invalid, so the first translated lookup misses.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are 1 and `flush` is 0. Its result is presented with `rsp_valid`=1 exactly one cycle after acceptance.
- R3: With `xlate_en`=0, an accepted request responds with `rsp_hit`=1, `rsp_fault`=0 and `rsp_paddr` equal to `req_laddr`. It never causes a miss.
- R4: With `page8k`=0, the set index is logical bits [15:12] and the tag is bits [31:16]. A hit returns `{pfn[19:0], laddr[11:0]}`.
- R5: With `page8k`=1, the set index is bits [16:13] and the tag is bits [31:17]. A hit returns `{pfn[19:1], laddr[12:0]}`, so logical bit 12 is part of the offset. An entry filled under one page size never hits a lookup made under the other size.
- R6: A translated lookup that matches no entry responds with `rsp_valid`=1, `rsp_hit`=0 and `rsp_fault`=0. In the same cycle `fill_req` rises and `req_ready` falls. `fill_lpn` then holds `laddr[31:12]` for 4 KB pages, or `{1'b0, laddr[31:13]}` for 8 KB pages.
- R7: While `fill_req` is 1, a cycle with `fill_valid`=1 writes the descriptor into the set. One cycle later the block does three things: it returns the waiting lookup's result judged against that descriptor, it drops `fill_req`, and it raises `req_ready`. Later lookups of that page hit.
- R8: A lookup with `req_super`=0 that reaches an entry marked supervisor-only responds with `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. The same access with `req_super`=1 translates normally.
- R9: A write (`req_write`=1) to a write-protected entry faults in either privilege mode. A read of that entry translates normally. Hit and fault are never reported together.
- R10: A fill goes to the lowest-numbered invalid way of its set. When all four ways are valid, it goes to the way named by that set's 2-bit round-robin pointer. The pointer starts at way 0 and advances by one after each such eviction.
- R11: A cycle with `flush`=1 makes three things happen. All entries become invalid. A pending miss is dropped, so there is no completion response, `fill_req` goes low and `fill_valid` is then ignored. A request offered in that cycle is discarded without a response.
- R12: While a miss is pending, requests are not accepted and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and drop a pending miss |
| xlate_en | input | 1 | 1 = translate, 0 = pass address through |
| page8k | input | 1 | Page size of the request: 0 = 4 KB, 1 = 8 KB |
| req_valid | input | 1 | Lookup request strobe |
| req_laddr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is in supervisor mode |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Protection violation |
| rsp_paddr | output | 32 | Physical address on a hit, 0 otherwise |
| fill_req | output | 1 | Descriptor wanted from the table-walk agent |
| fill_lpn | output | 20 | Logical page number of the missing page |
| fill_valid | input | 1 | Descriptor from the table-walk agent is present |
| fill_pfn | input | 20 | Physical frame number, in 4 KB units |
| fill_super | input | 1 | Descriptor marks the page supervisor-only |
| fill_wp | input | 1 | Descriptor marks the page write-protected |

## Verification
The assertions watch the cycle-level contract on every cycle:
- a response follows every acceptance one cycle later;
- pass-through returns the logical address unchanged;
- a miss outcome always comes with a raised fill request and a lowered ready;
- the block stays silent while a miss is pending;
- a fill completes in one cycle;
- a flush empties the store and cancels the pending miss;
- the victim choice is one-hot and never lands on a valid way while an invalid one exists.

Only the bench's scenarios can show that data-dependent results are right. These include the address fields used for index and tag under each page size, the physical address built from the frame number, the separation of 4 KB and 8 KB entries, the protection outcome for each mix of descriptor flags and access kind, and the order in which round-robin eviction removes pages.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int ADDR_W  = 32;
  localparam int PFN_W   = 20;
  localparam int PAGE_SH = 12;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             sup;
    logic             wp;
  } tlb_desc_t;

  // Physical address from a frame number (4 KB units) and a logical offset.
  function automatic logic [ADDR_W-1:0] form_paddr(input logic [PFN_W-1:0] pfn,
                                                   input logic [ADDR_W-1:0] la,
                                                   input logic big);
    if (big) return {pfn[PFN_W-1:1], la[PAGE_SH:0]};
    else     return {pfn, la[PAGE_SH-1:0]};
  endfunction

  // True when the access breaks the descriptor's protection flags.
  function automatic logic prot_viol(input tlb_desc_t d, input logic sup_mode,
                                     input logic wr);
    return (d.sup && !sup_mode) || (d.wp && wr);
  endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             we,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_big,
  input  tlb_desc_t        wr_desc,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_big,
  output logic             rd_hit,
  output tlb_desc_t        rd_desc,
  output logic             wr_set_vld
);

  logic [SETS-1:0] vld;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic             big_mem [SETS];
  tlb_desc_t        desc_mem[SETS];

  // Valid bits stay in flops so a flush clears them all at once.
  always_ff @(posedge clk) begin
    if (rst || flush) vld <= '0;
    else if (we)      vld[wr_set] <= 1'b1;
  end

  // Payload arrays: no reset, plain write port, asynchronous read.
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_set]  <= wr_tag;
      big_mem[wr_set]  <= wr_big;
      desc_mem[wr_set] <= wr_desc;
    end
  end

  assign rd_hit     = vld[rd_set] && (tag_mem[rd_set] == rd_tag) && (big_mem[rd_set] == rd_big);
  assign rd_desc    = desc_mem[rd_set];
  assign wr_set_vld = vld[wr_set];

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));

  a_r7_fill_marks_valid: assert property (@(posedge clk) disable iff (rst)
    (we && !flush) |=> vld[$past(wr_set)]);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int PTR_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             fill_we,
  output logic [WAYS-1:0]  way_sel
);

  logic [PTR_W-1:0] ptr [SETS];
  logic             found;

  always_comb begin
    way_sel = '0;
    found   = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_vec[w]) begin
        way_sel[w] = 1'b1;
        found      = 1'b1;
      end
    end
    if (!found) way_sel[ptr[set]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (fill_we && (&valid_vec)) begin
      ptr[set] <= ptr[set] + 1'b1;
    end
  end

  a_r10_victim_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(way_sel));

  a_r10_invalid_first: assert property (@(posedge clk) disable iff (rst)
    (fill_we && !(&valid_vec)) |-> ((way_sel & valid_vec) == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        xlate_en,
  input  logic        page8k,
  input  logic        req_valid,
  input  logic [31:0] req_laddr,
  input  logic        req_write,
  input  logic        req_super,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        fill_req,
  output logic [19:0] fill_lpn,
  input  logic        fill_valid,
  input  logic [19:0] fill_pfn,
  input  logic        fill_super,
  input  logic        fill_wp
);

  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - PAGE_SH - SET_W;

  // Lookup field extraction
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;

  always_comb begin
    if (page8k) begin
      lk_set = req_laddr[PAGE_SH+1 +: SET_W];
      lk_tag = {1'b0, req_laddr[ADDR_W-1:PAGE_SH+1+SET_W]};
    end else begin
      lk_set = req_laddr[PAGE_SH +: SET_W];
      lk_tag = req_laddr[ADDR_W-1:PAGE_SH+SET_W];
    end
  end

  // Pending-miss state
  logic             pend_q;
  logic [31:0]      pend_la;
  logic [SET_W-1:0] pend_set;
  logic [TAG_W-1:0] pend_tag;
  logic             pend_big;
  logic             pend_wr;
  logic             pend_sup;

  logic accept, fill_we;
  assign req_ready = !pend_q;
  assign fill_req  = pend_q;
  assign accept    = req_valid && req_ready && !flush;
  assign fill_we   = pend_q && fill_valid && !flush;

  tlb_desc_t fill_desc;
  assign fill_desc = '{pfn: fill_pfn, sup: fill_super, wp: fill_wp};

  // Ways
  logic [WAYS-1:0] way_hit, way_vld, way_sel;
  tlb_desc_t       way_desc [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way #(.SETS(SETS), .TAG_W(TAG_W)) u_way (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .we        (fill_we && way_sel[w]),
      .wr_set    (pend_set),
      .wr_tag    (pend_tag),
      .wr_big    (pend_big),
      .wr_desc   (fill_desc),
      .rd_set    (lk_set),
      .rd_tag    (lk_tag),
      .rd_big    (page8k),
      .rd_hit    (way_hit[w]),
      .rd_desc   (way_desc[w]),
      .wr_set_vld(way_vld[w])
    );
  end

  tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .set      (pend_set),
    .valid_vec(way_vld),
    .fill_we  (fill_we),
    .way_sel  (way_sel)
  );

  // Hit merge
  logic      hit_any;
  tlb_desc_t hit_desc;

  always_comb begin
    hit_any  = 1'b0;
    hit_desc = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        hit_any  = 1'b1;
        hit_desc = hit_desc | way_desc[w];
      end
    end
  end

  // Registered result and miss tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      pend_q    <= 1'b0;
      pend_la   <= '0;
      pend_set  <= '0;
      pend_tag  <= '0;
      pend_big  <= 1'b0;
      pend_wr   <= 1'b0;
      pend_sup  <= 1'b0;
      fill_lpn  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      if (flush) begin
        pend_q <= 1'b0;
      end else if (fill_we) begin
        rsp_valid <= 1'b1;
        pend_q    <= 1'b0;
        if (prot_viol(fill_desc, pend_sup, pend_wr)) begin
          rsp_fault <= 1'b1;
        end else begin
          rsp_hit   <= 1'b1;
          rsp_paddr <= form_paddr(fill_pfn, pend_la, pend_big);
        end
      end else if (accept) begin
        rsp_valid <= 1'b1;
        if (!xlate_en) begin
          rsp_hit   <= 1'b1;
          rsp_paddr <= req_laddr;
        end else if (hit_any) begin
          if (prot_viol(hit_desc, req_super, req_write)) begin
            rsp_fault <= 1'b1;
          end else begin
            rsp_hit   <= 1'b1;
            rsp_paddr <= form_paddr(hit_desc.pfn, req_laddr, page8k);
          end
        end else begin
          pend_q   <= 1'b1;
          pend_la  <= req_laddr;
          pend_set <= lk_set;
          pend_tag <= lk_tag;
          pend_big <= page8k;
          pend_wr  <= req_write;
          pend_sup <= req_super;
          fill_lpn <= page8k ? {1'b0, req_laddr[31:PAGE_SH+1]} : req_laddr[31:PAGE_SH];
        end
      end
    end
  end

  a_r2_one_cycle_result: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);

  a_r3_bypass_identity: assert property (@(posedge clk) disable iff (rst)
    (accept && !xlate_en) |=> (rsp_valid && rsp_hit && !rsp_fault && rsp_paddr == $past(req_laddr)));

  a_r6_miss_requests_fill: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && !rsp_fault) |-> (fill_req && !req_ready));

  a_r7_fill_completes: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_valid && !flush) |=> (rsp_valid && !fill_req && req_ready));

  a_r9_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_hit && rsp_fault));

  a_r11_flush_cancels: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!fill_req && !rsp_valid));

  a_r12_silent_while_pending: assert property (@(posedge clk) disable iff (rst)
    (fill_req && $past(fill_req)) |-> !rsp_valid);

endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, xlate_en = 1'b0, page8k = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [31:0] req_laddr = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_fault, fill_req;
  logic [31:0] rsp_paddr;
  logic [19:0] fill_lpn;
  logic        fill_valid = 1'b0, fill_super = 1'b0, fill_wp = 1'b0;
  logic [19:0] fill_pfn = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(input logic [19:0] pfn, input logic [31:0] a, input bit big);
    return big ? {pfn[19:1], a[12:0]} : {pfn, a[11:0]};
  endfunction

  // Flags packed as {rsp_valid, rsp_hit, rsp_fault}
  function automatic logic [31:0] flags();
    return {29'b0, rsp_valid, rsp_hit, rsp_fault};
  endfunction

  task automatic req(input logic [31:0] a, input bit wr, input bit sup, input bit en, input bit big);
    req_laddr = a; req_write = wr; req_super = sup; xlate_en = en; page8k = big; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] pfn, input bit s, input bit wp);
    fill_pfn = pfn; fill_super = s; fill_wp = wp; fill_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
  endtask

  // Lookup expected to miss, then fill and check the completion.
  task automatic miss_fill(input string r, input logic [31:0] a, input bit big, input bit wr,
                           input bit sup, input logic [19:0] pfn, input bit s, input bit wp);
    bit viol;
    req(a, wr, sup, 1'b1, big);
    chk({r, " R6 miss flags"}, flags(), 32'b100);
    chk({r, " R6 fill_req/ready"}, {30'b0, fill_req, req_ready}, 32'b10);
    chk({r, " R6 fill_lpn"}, {12'b0, fill_lpn}, big ? {13'b0, a[31:13]} : {12'b0, a[31:12]});
    fill(pfn, s, wp);
    viol = (s && !sup) || (wp && wr);
    chk({r, " R7 completion flags"}, flags(), {29'b0, 1'b1, !viol, viol});
    chk({r, " R7 completion paddr"}, rsp_paddr, viol ? 32'h0 : exp_pa(pfn, a, big));
    chk({r, " R7 fill_req/ready after"}, {30'b0, fill_req, req_ready}, 32'b01);
  endtask

  task automatic hit_chk(input string r, input logic [31:0] a, input bit big,
                         input logic [19:0] pfn);
    req(a, 1'b0, 1'b1, 1'b1, big);
    chk({r, " hit flags"}, flags(), 32'b110);
    chk({r, " hit paddr"}, rsp_paddr, exp_pa(pfn, a, big));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [19:0] p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 ready/fill_req in reset", {30'b0, req_ready, fill_req}, 32'b10);
    rst = 1'b0;
    @(negedge clk);

    // R3: pass-through sweep
    for (int i = 0; i < 8; i++) begin
      a = (i * 32'h1357_9BDF) ^ 32'hC3A5_0F1E;
      req(a, i[0], i[1], 1'b0, i[2]);
      chk("R3 bypass flags", flags(), 32'b110);
      chk("R3 bypass paddr", rsp_paddr, a);
      chk("R3 bypass no fill", {31'b0, fill_req}, 32'd0);
    end

    // R1, R4, R6, R7: 4 KB sweep over all sets
    for (int s = 0; s < 16; s++) begin
      a = {16'(16'h1000 + s * 7), 4'(s), 12'(s * 37 + 1)};
      p = 20'hA0000 ^ 20'(s * 291);
      miss_fill(s == 0 ? "R1 first lookup" : "R4 sweep", a, 1'b0, 1'b0, 1'b1, p, 1'b0, 1'b0);
    end
    for (int s = 0; s < 16; s++) begin
      a = {16'(16'h1000 + s * 7), 4'(s), 12'(s * 53 + 9)};
      p = 20'hA0000 ^ 20'(s * 291);
      hit_chk("R4 4K", a, 1'b0, p);
    end
    req(32'h1000_F123 ^ 32'h0001_0000, 1'b0, 1'b1, 1'b1, 1'b0);   // same set, other tag
    chk("R4 tag mismatch misses", flags(), 32'b100);
    do_flush();

    // R8, R9: every descriptor flag mix against every access kind
    for (int k = 0; k < 4; k++) begin
      a = {16'(16'h2200 + k), 4'(k + 3), 12'h0A4};
      p = 20'(20'h33000 + k * 5);
      miss_fill("R8 prot fill", a, 1'b0, 1'b0, 1'b1, p, k[0], k[1]);
      for (int acc = 0; acc < 4; acc++) begin
        bit viol;
        viol = (k[0] && !acc[0]) || (k[1] && acc[1]);
        req(a, acc[1], acc[0], 1'b1, 1'b0);
        chk(k[0] ? "R8 supervisor flag" : "R9 write protect", flags(), {29'b0, 1'b1, !viol, viol});
        chk("R8 R9 paddr", rsp_paddr, viol ? 32'h0 : exp_pa(p, a, 1'b0));
      end
    end
    miss_fill("R9 write miss on protected page", 32'h7777_8123, 1'b0, 1'b1, 1'b1, 20'h12345, 1'b0, 1'b1);
    miss_fill("R8 user miss on supervisor page", 32'h7778_9456, 1'b0, 1'b0, 1'b0, 20'h54321, 1'b1, 1'b0);
    do_flush();

    // R10: replacement order in set 5
    for (int t = 0; t < 5; t++)
      miss_fill("R10 fill", {16'(16'h0200 + t), 4'd5, 12'h010}, 1'b0, 1'b0, 1'b1,
                20'(20'h00100 + t), 1'b0, 1'b0);
    for (int t = 1; t < 5; t++)
      hit_chk("R10 survivor", {16'(16'h0200 + t), 4'd5, 12'h020}, 1'b0, 20'(20'h00100 + t));
    miss_fill("R10 first victim was way 0", {16'h0200, 4'd5, 12'h030}, 1'b0, 1'b0, 1'b1,
              20'h00100, 1'b0, 1'b0);
    req({16'h0201, 4'd5, 12'h040}, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 second victim was way 1", flags(), 32'b100);
    do_flush();
    chk("R11 flush drops pending miss", {29'b0, fill_req, req_ready, rsp_valid}, 32'b010);
    fill(20'h0BEEF, 1'b0, 1'b0);
    chk("R11 fill after flush ignored", {31'b0, rsp_valid}, 32'd0);
    req({16'h0202, 4'd5, 12'h050}, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R11 flushed entry misses", flags(), 32'b100);
    do_flush();

    // R5: 8 KB sweep
    for (int s = 0; s < 16; s++) begin
      a = {15'(15'h0400 + s * 3), 4'(s), 13'(s * 101 + 5)};
      p = 20'(20'h50001 + (s << 4));
      miss_fill("R5 8K fill", a, 1'b1, 1'b0, 1'b1, p, 1'b0, 1'b0);
    end
    for (int s = 0; s < 16; s++) begin
      a = {15'(15'h0400 + s * 3), 4'(s), 13'(s * 101 + 5)} ^ 32'h0000_1000;
      p = 20'(20'h50001 + (s << 4));
      hit_chk("R5 8K bit12 offset", a, 1'b1, p);
    end
    b = {15'h0400 + 15'd6, 4'd2, 13'h0000};
    req(b, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 8K entry not seen at 4K", flags(), 32'b100);

    // R12: request while pending is ignored
    req(32'h0BAD_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R12 no response while pending", {30'b0, rsp_valid, fill_req}, 32'b01);
    fill(20'h11110, 1'b0, 1'b0);
    chk("R12 completion is the stalled miss", rsp_paddr, exp_pa(20'h11110, b, 1'b0));

    // R11: request offered during flush is discarded, and R2 timing
    flush = 1'b1;
    req(32'h0000_1234, 1'b0, 1'b1, 1'b0, 1'b0);
    flush = 1'b0;
    chk("R11 request during flush dropped", {31'b0, rsp_valid}, 32'd0);
    req(32'h0000_5678, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 response one cycle after accept", {31'b0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R2 response lasts one cycle", {31'b0, rsp_valid}, 32'd0);
    req({16'h1003, 4'd3, 12'h000}, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R11 all entries cleared", flags(), 32'b100);
    do_flush();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule